// File: doc/BRIEF.md
# Banked GPIO Controller with Pin Interrupts

This block is a register-mapped general-purpose I/O controller. It is organised as a parameterised number of banks, with 32 pins per bank. Software reaches it over a plain synchronous bus that has a byte address, a write strobe with write data, and a read strobe. Read data comes back one cycle after the read strobe. For each pin, the controller holds an output value and a drive enable. It also samples the pad level through a two-flop synchroniser, and it can turn a chosen edge or level on the pin into a sticky status bit.

Each writable register has four write addresses. One replaces the whole word, and the other three set, clear or invert only the bits written as 1. Software can therefore change single pins without a read-modify-write sequence.

Every interrupt-capable pin picks one of four conditions. The condition comes from two per-pin bits: a level bit (1 = level, 0 = edge) and a polarity bit (1 = high or rising, 0 = low or falling). The enabled status bits of all banks are ORed into one registered, active-high interrupt line.

Byte address layout:
- bits [10:8] select the register kind: 0 output value, 1 sampled input, 2 drive enable, 3 interrupt select, 4 interrupt enable, 5 status, 6 level bit, 7 polarity bit.
- bits [7:4] select the bank, so consecutive banks of one kind sit 0x10 apart.
- bits [3:2] select the write operation: +0 write, +4 set, +8 clear, +0xC toggle.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After a synchronous reset, all output-value, drive-enable, select, enable, status, level and polarity bits are 0. `pad_out`, `pad_oe`, `irq` and `rdata` are also 0.
- R2: A register of kind k for bank n is at byte address k*0x100 + n*0x10. A write to offset +0 replaces the word, and a read of any of the four offsets returns the word on `rdata` in the cycle after `rd_en`.
- R3: A write to offset +4 sets each bit written as 1 and leaves every other bit unchanged.
- R4: A write to offset +8 clears each bit written as 1 and leaves every other bit unchanged. This also applies to the status kind.
- R5: A write to offset +0xC inverts each bit written as 1 and leaves every other bit unchanged.
- R6: `pad_out` bit n*32+p equals output-value bit p of bank n, and `pad_oe` bit n*32+p equals drive-enable bit p of bank n. A value of 1 in `pad_oe` means the pin is driven.
- R7: Kind 1 reads the pad levels through a two-flop synchroniser. Writes to kind 1 change nothing.
- R8: Edge modes, with {polarity, level} = 10 for rising and 00 for falling, set the status bit when the synchronised sample differs from the previous sample in the chosen direction. The bit stays set after the pin returns, until it is cleared. An edge in the other direction does not set it.
- R9: Level modes, with {polarity, level} = 11 for high and 01 for low, set the status bit on every cycle while the level is present. The bit comes back right after a clear if the level is still present.
- R10: A status bit is set by hardware only when the pin's interrupt-select bit is 1.
- R11: `irq` is a register that holds the OR, over all banks and pins, of status AND enable. It rises one cycle after the status bit is set, which is four clock edges after the pad changes.
- R12: An address whose bank index is NUM_BANKS or higher, or whose bits above bit 10 are not zero, reads as 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W | Byte address |
| wr_en | input | 1 | Write strobe |
| wdata | input | PINS | Write data |
| rd_en | input | 1 | Read strobe |
| rdata | output | PINS | Read data, valid the cycle after rd_en |
| pad_in | input | NUM_BANKS*PINS | Pad input levels |
| pad_out | output | NUM_BANKS*PINS | Pad output values |
| pad_oe | output | NUM_BANKS*PINS | Pad drive enables |
| irq | output | 1 | Combined interrupt, active high |

## Verification
The bench builds the block with its defaults: five banks of 32 pins and a 12-bit address. With five banks, the highest valid bank (index 4) and the first unmapped index (5) both fit in the 4-bit bank field. The bench therefore exercises both sides of the decode boundary, and it runs level-mode tests in the top bank. Running the edge and level tests in separate banks also checks that pad positions map to the correct bank slices.

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl #(
  parameter int NUM_BANKS = 5,
  parameter int PINS      = 32,
  parameter int ADDR_W    = 12
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [ADDR_W-1:0]         addr,
  input  logic                      wr_en,
  input  logic [PINS-1:0]           wdata,
  input  logic                      rd_en,
  output logic [PINS-1:0]           rdata,
  input  logic [NUM_BANKS*PINS-1:0] pad_in,
  output logic [NUM_BANKS*PINS-1:0] pad_out,
  output logic [NUM_BANKS*PINS-1:0] pad_oe,
  output logic                      irq
);
  localparam int TOTAL = NUM_BANKS * PINS;
  localparam logic [2:0] K_DOUT = 3'd0, K_DIN = 3'd1, K_OE = 3'd2, K_SEL = 3'd3,
                         K_IEN = 3'd4, K_STAT = 3'd5, K_LVL = 3'd6, K_POL = 3'd7;

  wire [2:0] kind = addr[10:8];
  wire [3:0] bank = addr[7:4];
  wire [1:0] op   = addr[3:2];
  wire       in_range = (addr >> 11) == '0;

  function automatic logic [PINS-1:0] upd(input logic [PINS-1:0] cur,
                                          input logic [PINS-1:0] w,
                                          input logic [1:0] o);
    case (o)
      2'd0:    upd = w;
      2'd1:    upd = cur | w;
      2'd2:    upd = cur & ~w;
      default: upd = cur ^ w;
    endcase
  endfunction

  logic [PINS-1:0] dout_r [NUM_BANKS];
  logic [PINS-1:0] oe_r   [NUM_BANKS];
  logic [PINS-1:0] sel_r  [NUM_BANKS];
  logic [PINS-1:0] ien_r  [NUM_BANKS];
  logic [PINS-1:0] stat_r [NUM_BANKS];
  logic [PINS-1:0] lvl_r  [NUM_BANKS];
  logic [PINS-1:0] pol_r  [NUM_BANKS];
  logic [TOTAL-1:0] s1, s2, s3;
  logic [NUM_BANKS-1:0] pend;
  logic [1:0] age;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= '0; s2 <= '0; s3 <= '0;
      age <= '0;
    end else begin
      s1 <= pad_in; s2 <= s1; s3 <= s2;
      if (age != 2'd3) age <= age + 2'd1;
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    wire             wsel = wr_en && in_range && (bank == 4'(b));
    wire [PINS-1:0]  cur  = s2[b*PINS +: PINS];
    wire [PINS-1:0]  prv  = s3[b*PINS +: PINS];
    wire [PINS-1:0]  lv   = lvl_r[b];
    wire [PINS-1:0]  pl   = pol_r[b];
    wire [PINS-1:0]  cond = (lv & pl & cur) | (lv & ~pl & ~cur) |
                            (~lv & pl & cur & ~prv) | (~lv & ~pl & ~cur & prv);
    wire [PINS-1:0]  hit  = cond & sel_r[b];

    always_ff @(posedge clk) begin
      if (rst) begin
        dout_r[b] <= '0; oe_r[b] <= '0; sel_r[b] <= '0; ien_r[b] <= '0;
        stat_r[b] <= '0; lvl_r[b] <= '0; pol_r[b] <= '0;
      end else begin
        if (wsel && kind == K_DOUT) dout_r[b] <= upd(dout_r[b], wdata, op);
        if (wsel && kind == K_OE)   oe_r[b]   <= upd(oe_r[b],   wdata, op);
        if (wsel && kind == K_SEL)  sel_r[b]  <= upd(sel_r[b],  wdata, op);
        if (wsel && kind == K_IEN)  ien_r[b]  <= upd(ien_r[b],  wdata, op);
        if (wsel && kind == K_LVL)  lvl_r[b]  <= upd(lvl_r[b],  wdata, op);
        if (wsel && kind == K_POL)  pol_r[b]  <= upd(pol_r[b],  wdata, op);
        stat_r[b] <= ((wsel && kind == K_STAT) ? upd(stat_r[b], wdata, op) : stat_r[b]) | hit;
      end
    end

    assign pad_out[b*PINS +: PINS] = dout_r[b];
    assign pad_oe[b*PINS +: PINS]  = oe_r[b];
    assign pend[b] = |(stat_r[b] & ien_r[b]);

    // R10
    sel_gate_chk: assert property (@(posedge clk) disable iff (rst)
      !wr_en |=> ((stat_r[b] & ~$past(stat_r[b]) & ~$past(sel_r[b])) == '0));
  end

  logic [PINS-1:0] rd_val;
  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NUM_BANKS; i++) begin
      if (in_range && bank == 4'(i)) begin
        case (kind)
          K_DOUT:  rd_val = dout_r[i];
          K_DIN:   rd_val = s2[i*PINS +: PINS];
          K_OE:    rd_val = oe_r[i];
          K_SEL:   rd_val = sel_r[i];
          K_IEN:   rd_val = ien_r[i];
          K_STAT:  rd_val = stat_r[i];
          K_LVL:   rd_val = lvl_r[i];
          default: rd_val = pol_r[i];
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      irq   <= 1'b0;
    end else begin
      if (rd_en) rdata <= rd_val;
      irq <= |pend;
    end
  end

  // R7
  din_sync_chk: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3) |-> (s2 == $past(pad_in, 2)));
  // R6
  pad_out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(pad_out));
  // R6
  pad_oe_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(pad_oe));
  // R12
  unmapped_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (!in_range || 32'(bank) >= NUM_BANKS)) |=> (rdata == '0));
endmodule

// File: tb/tb_gpio_bank_ctrl.sv
module tb_gpio_bank_ctrl;
  localparam int NB = 5;
  localparam int P  = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [11:0] addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [P-1:0] wdata = '0;
  logic [P-1:0] rdata;
  logic [NB*P-1:0] pad_in = '0;
  logic [NB*P-1:0] pad_out, pad_oe;
  logic irq;
  int checks = 0, errors = 0;

  gpio_bank_ctrl #(.NUM_BANKS(NB), .PINS(P), .ADDR_W(12)) dut (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rd_en(rd_en), .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .irq(irq));

  always #4 clk = ~clk;

  function automatic logic [11:0] A(input int kind, input int bank, input int op);
    A = 12'(kind * 256 + bank * 16 + op * 4);
  endfunction

  task automatic chk(input string req, input logic [P-1:0] act, input logic [P-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [P-1:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [P-1:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [P-1:0] v;
    chk("R1 pad_out", pad_out[P-1:0] | pad_out[NB*P-1 -: P], '0);
    chk("R1 pad_oe", pad_oe[P-1:0] | pad_oe[NB*P-1 -: P], '0);
    chk("R1 irq", P'(irq), '0);
    for (int k = 0; k < 8; k++) begin
      if (k == 1) continue;
      rd(A(k, 4, 0), v);
      chk("R1 reg", v, '0);
    end
  endtask

  task automatic t_plain();
    logic [P-1:0] v;
    wr(A(0, 1, 0), 32'hA5A5_3C3C);
    rd(A(0, 1, 0), v);  chk("R2 write/read", v, 32'hA5A5_3C3C);
    rd(A(0, 1, 3), v);  chk("R2 alias read", v, 32'hA5A5_3C3C);
    chk("R6 pad_out slice", pad_out[1*P +: P], 32'hA5A5_3C3C);
  endtask

  task automatic t_alias();
    logic [P-1:0] v;
    wr(A(2, 2, 0), 32'h0000_00F0);
    wr(A(2, 2, 1), 32'h0000_000F);
    rd(A(2, 2, 0), v);  chk("R3 set", v, 32'h0000_00FF);
    wr(A(2, 2, 2), 32'h0000_0030);
    rd(A(2, 2, 0), v);  chk("R4 clear", v, 32'h0000_00CF);
    wr(A(2, 2, 3), 32'hFF00_00FF);
    rd(A(2, 2, 0), v);  chk("R5 toggle", v, 32'hFF00_0030);
    chk("R6 pad_oe slice", pad_oe[2*P +: P], 32'hFF00_0030);
  endtask

  task automatic t_din();
    logic [P-1:0] v;
    @(negedge clk); pad_in[3*P +: P] = 32'h1234_5678;
    wait_n(3);
    rd(A(1, 3, 0), v);  chk("R7 din", v, 32'h1234_5678);
    wr(A(1, 3, 0), 32'hFFFF_FFFF);
    rd(A(1, 3, 0), v);  chk("R7 din write ignored", v, 32'h1234_5678);
  endtask

  task automatic t_unmapped();
    logic [P-1:0] v;
    logic [NB*P-1:0] before_o, before_e;
    before_o = pad_out; before_e = pad_oe;
    wr(A(0, 5, 0), 32'hFFFF_FFFF);
    wr(A(2, 5, 1), 32'hFFFF_FFFF);
    wr(12'h800 | A(0, 1, 0), 32'h0);
    chk("R12 pad_out untouched", P'(pad_out != before_o), '0);
    chk("R12 pad_oe untouched", P'(pad_oe != before_e), '0);
    rd(A(0, 5, 0), v);  chk("R12 unmapped read", v, '0);
    rd(12'h800 | A(0, 1, 0), v);  chk("R12 high address read", v, '0);
  endtask

  task automatic t_edge();
    logic [P-1:0] v;
    wr(A(3, 0, 0), 32'h8);
    wr(A(7, 0, 0), 32'h8);
    wr(A(4, 0, 0), 32'h8);
    @(negedge clk); pad_in[3] = 1'b1;
    wait_n(3);
    chk("R11 irq not yet", P'(irq), '0);
    wait_n(1);
    chk("R11 irq raised", P'(irq), 1);
    @(negedge clk); pad_in[3] = 1'b0;
    wait_n(5);
    rd(A(5, 0, 0), v);  chk("R8 rising sticky", v, 32'h8);
    wr(A(5, 0, 2), 32'h8);
    rd(A(5, 0, 0), v);  chk("R4 status clear", v, '0);
    wait_n(1);
    chk("R11 irq dropped", P'(irq), '0);
    wr(A(7, 0, 2), 32'h8);
    @(negedge clk); pad_in[3] = 1'b1;
    wait_n(5);
    rd(A(5, 0, 0), v);  chk("R8 rising ignored in falling mode", v, '0);
    @(negedge clk); pad_in[3] = 1'b0;
    wait_n(5);
    rd(A(5, 0, 0), v);  chk("R8 falling edge", v, 32'h8);
    wr(A(5, 0, 2), 32'h8);
    wait_n(2);
  endtask

  task automatic t_level();
    logic [P-1:0] v;
    wr(A(3, 4, 0), 32'h20);
    wr(A(6, 4, 0), 32'h20);
    wr(A(7, 4, 0), 32'h20);
    @(negedge clk); pad_in[4*P + 5] = 1'b1;
    wait_n(4);
    wr(A(5, 4, 2), 32'h20);
    rd(A(5, 4, 0), v);  chk("R9 high level re-set after clear", v, 32'h20);
    @(negedge clk); pad_in[4*P + 5] = 1'b0;
    wait_n(4);
    wr(A(5, 4, 2), 32'h20);
    rd(A(5, 4, 0), v);  chk("R9 high level gone", v, '0);
    wr(A(7, 4, 2), 32'h20);
    wait_n(2);
    rd(A(5, 4, 0), v);  chk("R9 low level", v, 32'h20);
    @(negedge clk); pad_in[4*P + 5] = 1'b1;
    wait_n(4);
    wr(A(5, 4, 2), 32'h20);
    rd(A(5, 4, 0), v);  chk("R9 low level gone", v, '0);
  endtask

  task automatic t_nosel();
    logic [P-1:0] v;
    wr(A(6, 2, 0), 32'h1);
    wr(A(7, 2, 0), 32'h1);
    wr(A(4, 2, 0), 32'h1);
    @(negedge clk); pad_in[2*P] = 1'b1;
    wait_n(5);
    rd(A(5, 2, 0), v);  chk("R10 no select no status", v, '0);
    chk("R10 irq quiet", P'(irq), '0);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait_n(4);
    rst = 1'b0;
    wait_n(1);
    t_reset();
    t_plain();
    t_alias();
    t_din();
    t_unmapped();
    t_edge();
    t_level();
    t_nosel();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule